// File: doc/BRIEF.md
# Vector-Class Geometric Product Unit

This block forms the geometric product of two four-field homogeneous elements of four-dimensional Euclidean geometric algebra. Each operand is either a vector or a trivector. An operand arrives as a 3-bit type tag and four 32-bit coefficients. The unit computes all sixteen coefficient cross-products in parallel. It negates each one according to a sign pattern chosen by the pair of operand tags. It then accumulates the products into a two-part result: one single-field part, which is a scalar or a pseudoscalar, and one six-field bivector.

A single routing network serves all four operand pairings. When one operand is a vector and the other a trivector, each result blade is the dual of the one a vector-vector product would give. The unit therefore mirrors the bivector slots and reports a pseudoscalar in place of the scalar, instead of keeping a second adder tree. Operands enter on a valid/ready stream and results leave on another. A result register decouples the two sides. The upstream side stalls only while a finished result waits for a consumer that is not ready. An input may be accepted in the same cycle as the held result drains.

Top module: `gp_vec_class_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An operand pair is taken on a rising edge where in_valid and in_ready are both 1. Its result appears with out_valid at 1 after that same edge. in_ready equals (not out_valid) or out_ready.
- R3: While out_valid is 1 and out_ready is 0, out_valid stays 1 and every result port holds its value.
- R4: Tag 001 marks a vector, with fields 0..3 holding e1, e2, e3, e4. Tag 101 marks a trivector, with fields 0..3 holding e234, e134, e124, e123. Field k of in_a or in_b sits at bits [32k+31:32k]. Field k of out_q sits at the same bit position, and fields 0..5 of out_q hold e12, e13, e14, e23, e24, e34.
- R5: For vector times vector, out_tag_p is 000 and out_p is A1A2+B1B2+C1C2+D1D2. Each bivector field eij is Xi·Yj − Xj·Yi.
- R6: For vector times trivector, out_tag_p is 100 and out_p is A1A2−B1B2+C1C2−D1D2. The bivector fields follow the Euclidean geometric product.
- R7: For trivector times vector, out_tag_p is 100 and all fields follow the Euclidean geometric product.
- R8: For trivector times trivector, out_tag_p is 000 and all fields follow the Euclidean geometric product.
- R9: Every result with out_err at 0 carries out_tag_q equal to 010.
- R10: Products and sums are 32-bit two's complement. Each product keeps its low 32 bits and each sum wraps.
- R11: If either operand tag is neither 001 nor 101, the result has out_err at 1, both tags at 000, and out_p and out_q all zero.
- R12: With out_ready held at 1, a new operand pair is accepted on every cycle without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can take an operand pair |
| in_tag_a | input | 3 | Type tag of the first operand |
| in_a | input | 128 | Four coefficients of the first operand |
| in_tag_b | input | 3 | Type tag of the second operand |
| in_b | input | 128 | Four coefficients of the second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_tag_p | output | 3 | Tag of the single-field part (000 scalar, 100 pseudoscalar) |
| out_p | output | 32 | Scalar or pseudoscalar coefficient |
| out_tag_q | output | 3 | Tag of the bivector part |
| out_q | output | 192 | Six bivector coefficients |
| out_err | output | 1 | Unsupported operand tag seen |

## Verification
The assertions check the stream rules on every cycle: the ready relation, the result appearing one edge after acceptance, and the result being held under back-pressure. They also check that the result tags match the operand tags, and that an illegal tag gives a zeroed, flagged result. Only the bench scenarios can show that the coefficients are correct. The bench checks signs, the slot mirroring for mixed pairings, and wraparound on large operands against an independent blade-mask model of the algebra. It also confirms that a burst is accepted without stalls while the consumer stays ready.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int FLD = 4;
  localparam int NPR = FLD * FLD;
  localparam int NBV = FLD * (FLD - 1) / 2;

  localparam logic [2:0] TAG_SCA = 3'b000;
  localparam logic [2:0] TAG_VEC = 3'b001;
  localparam logic [2:0] TAG_BIV = 3'b010;
  localparam logic [2:0] TAG_PSC = 3'b100;
  localparam logic [2:0] TAG_TRI = 3'b101;

  // basis-blade mask of coefficient idx; a dual operand holds complements
  function automatic logic [FLD-1:0] blade_of(input logic dual, input int idx);
    logic [FLD-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return dual ? ~m : m;
  endfunction

  // parity of transpositions to bring e_a e_b into canonical order
  function automatic logic reorder_odd(input logic [FLD-1:0] a, input logic [FLD-1:0] b);
    logic par;
    par = 1'b0;
    for (int i = 0; i < FLD; i++)
      if (b[i])
        for (int k = i + 1; k < FLD; k++)
          if (a[k]) par = ~par;
    return par;
  endfunction

  // negate-mask, bit i*FLD+j for coefficient pair (i, j)
  function automatic logic [NPR-1:0] sign_table(input logic da, input logic db);
    logic [NPR-1:0] t;
    t = '0;
    for (int i = 0; i < FLD; i++)
      for (int j = 0; j < FLD; j++)
        t[i*FLD+j] = reorder_odd(blade_of(da, i), blade_of(db, j));
    return t;
  endfunction

  // bivector slot of the unordered index pair (lo, hi), lo < hi
  function automatic int pair_slot(input int i, input int j);
    int lo, hi;
    lo = (i < j) ? i : j;
    hi = (i < j) ? j : i;
    return lo * FLD - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

  function automatic logic four_field(input logic [2:0] tag);
    return (tag == TAG_VEC) || (tag == TAG_TRI);
  endfunction
endpackage

// File: rtl/gp_sign_lut.sv
module gp_sign_lut
  import gp_pkg::*;
(
  input  logic [2:0]     tag_a,
  input  logic [2:0]     tag_b,
  output logic [NPR-1:0] neg_mask,
  output logic           legal,
  output logic           mixed
);
  localparam logic [NPR-1:0] M_VV = sign_table(1'b0, 1'b0);
  localparam logic [NPR-1:0] M_VT = sign_table(1'b0, 1'b1);
  localparam logic [NPR-1:0] M_TV = sign_table(1'b1, 1'b0);
  localparam logic [NPR-1:0] M_TT = sign_table(1'b1, 1'b1);

  always_comb begin
    legal = four_field(tag_a) && four_field(tag_b);
    mixed = tag_a[2] ^ tag_b[2];
    unique case ({tag_a[2], tag_b[2]})
      2'b00:   neg_mask = M_VV;
      2'b01:   neg_mask = M_VT;
      2'b10:   neg_mask = M_TV;
      default: neg_mask = M_TT;
    endcase
    if (!legal) neg_mask = '0;
  end
endmodule

// File: rtl/gp_product_array.sv
module gp_product_array
  import gp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [FLD*W-1:0] opa,
  input  logic [FLD*W-1:0] opb,
  input  logic [NPR-1:0]   neg_mask,
  output logic [NPR*W-1:0] prod
);
  for (genvar i = 0; i < FLD; i++) begin : g_row
    for (genvar j = 0; j < FLD; j++) begin : g_col
      logic [W-1:0] raw;
      assign raw = opa[i*W +: W] * opb[j*W +: W];
      assign prod[(i*FLD+j)*W +: W] = neg_mask[i*FLD+j] ? (~raw + 1'b1) : raw;
    end
  end
endmodule

// File: rtl/gp_route_sum.sv
module gp_route_sum
  import gp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [NPR*W-1:0] prod,
  input  logic             mirror,
  output logic [W-1:0]     sum_p,
  output logic [NBV*W-1:0] sum_q
);
  logic [W-1:0] acc [NBV];
  logic [W-1:0] acc_p;

  always_comb begin
    acc_p = '0;
    for (int s = 0; s < NBV; s++) acc[s] = '0;
    for (int i = 0; i < FLD; i++) begin
      for (int j = 0; j < FLD; j++) begin
        if (i == j) begin
          acc_p = acc_p + prod[(i*FLD+j)*W +: W];
        end else begin
          acc[pair_slot(i, j)] = acc[pair_slot(i, j)] + prod[(i*FLD+j)*W +: W];
        end
      end
    end
  end

  assign sum_p = acc_p;

  // dual pairing lands each blade in its complement slot
  for (genvar s = 0; s < NBV; s++) begin : g_slot
    assign sum_q[s*W +: W] = mirror ? acc[NBV-1-s] : acc[s];
  end
endmodule

// File: rtl/gp_vec_class_unit.sv
module gp_vec_class_unit
  import gp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_tag_a,
  input  logic [FLD*W-1:0] in_a,
  input  logic [2:0]       in_tag_b,
  input  logic [FLD*W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_tag_p,
  output logic [W-1:0]     out_p,
  output logic [2:0]       out_tag_q,
  output logic [NBV*W-1:0] out_q,
  output logic             out_err
);
  logic [NPR-1:0]   neg_mask;
  logic             legal;
  logic             mixed;
  logic [NPR*W-1:0] prod;
  logic [W-1:0]     sum_p;
  logic [NBV*W-1:0] sum_q;
  logic             take;

  gp_sign_lut u_lut (
    .tag_a    (in_tag_a),
    .tag_b    (in_tag_b),
    .neg_mask (neg_mask),
    .legal    (legal),
    .mixed    (mixed)
  );

  gp_product_array #(.W(W)) u_mul (
    .opa      (in_a),
    .opb      (in_b),
    .neg_mask (neg_mask),
    .prod     (prod)
  );

  gp_route_sum #(.W(W)) u_sum (
    .prod   (prod),
    .mirror (mixed),
    .sum_p  (sum_p),
    .sum_q  (sum_q)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tag_p <= TAG_SCA;
      out_tag_q <= TAG_SCA;
      out_p     <= '0;
      out_q     <= '0;
      out_err   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_err   <= !legal;
      if (legal) begin
        out_tag_p <= mixed ? TAG_PSC : TAG_SCA;
        out_tag_q <= TAG_BIV;
        out_p     <= sum_p;
        out_q     <= sum_q;
      end else begin
        out_tag_p <= TAG_SCA;
        out_tag_q <= TAG_SCA;
        out_p     <= '0;
        out_q     <= '0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gp_vec_class_unit_chk.sv
module gp_vec_class_unit_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     in_tag_a,
  input logic [2:0]     in_tag_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2:0]     out_tag_p,
  input logic [W-1:0]   out_p,
  input logic [2:0]     out_tag_q,
  input logic [6*W-1:0] out_q,
  input logic           out_err
);
  logic ok_a, ok_b;
  assign ok_a = (in_tag_a == 3'b001) || (in_tag_a == 3'b101);
  assign ok_b = (in_tag_b == 3'b001) || (in_tag_b == 3'b101);

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R2
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_q)
      && $stable(out_tag_p) && $stable(out_tag_q) && $stable(out_err)); // R3
  AST_BIV_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_tag_q == 3'b010); // R9
  AST_MIXED_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ok_a && ok_b && (in_tag_a[2] != in_tag_b[2])
      |=> out_tag_p == 3'b100 && !out_err); // R6
  AST_SAME_SCA: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ok_a && ok_b && (in_tag_a[2] == in_tag_b[2])
      |=> out_tag_p == 3'b000 && !out_err); // R5
  AST_BAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !(ok_a && ok_b) |=> out_err); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_p == '0 && out_q == '0
      && out_tag_p == 3'b000 && out_tag_q == 3'b000); // R11
endmodule

bind gp_vec_class_unit gp_vec_class_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_tag_a  (in_tag_a),
  .in_tag_b  (in_tag_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tag_p (out_tag_p),
  .out_p     (out_p),
  .out_tag_q (out_tag_q),
  .out_q     (out_q),
  .out_err   (out_err)
);

// File: tb/gp_vec_class_unit_bench.sv
module gp_vec_class_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_tag_a = 3'b0;
  logic [127:0] in_a = '0;
  logic [2:0]   in_tag_b = 3'b0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [2:0]   out_tag_p;
  logic [31:0]  out_p;
  logic [2:0]   out_tag_q;
  logic [191:0] out_q;
  logic         out_err;

  always #5 clk = ~clk;

  gp_vec_class_unit u_gp_vec_class_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag_a(in_tag_a), .in_a(in_a), .in_tag_b(in_tag_b), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag_p(out_tag_p),
    .out_p(out_p), .out_tag_q(out_tag_q), .out_q(out_q), .out_err(out_err)
  );

  typedef struct packed {
    logic [2:0]   tp;
    logic [2:0]   tq;
    logic         err;
    logic [31:0]  p;
    logic [191:0] q;
  } res_t;

  res_t  exp_q[$];
  string req_q[$];
  int    checks = 0;
  int    errors = 0;
  int    stalls = 0;
  bit    bp_mode = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic [31:0] bp_lfsr = 32'hACE1_0F0F;

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Euclidean blade reordering parity, independent model
  function automatic logic odd_swaps(input logic [3:0] a, input logic [3:0] b);
    int n;
    n = 0;
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++)
        if (a[x] && b[y] && x > y) n++;
    return n[0];
  endfunction

  function automatic int biv_field(input logic [3:0] m);
    case (m)
      4'b0011: return 0;
      4'b0101: return 1;
      4'b1001: return 2;
      4'b0110: return 3;
      4'b1010: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic res_t model(input logic [2:0] ta, input logic [127:0] a,
                                 input logic [2:0] tb, input logic [127:0] b);
    res_t r;
    logic [3:0] ma, mb, t;
    logic [31:0] pr;
    r = '0;
    if (!((ta == 3'b001 || ta == 3'b101) && (tb == 3'b001 || tb == 3'b101))) begin
      r.err = 1'b1;
      return r;
    end
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        ma = 4'(1 << i);
        mb = 4'(1 << j);
        if (ta[2]) ma = ~ma;
        if (tb[2]) mb = ~mb;
        t  = ma ^ mb;
        pr = a[i*32 +: 32] * b[j*32 +: 32];
        if (odd_swaps(ma, mb)) pr = -pr;
        if (t == 4'h0 || t == 4'hF) r.p = r.p + pr;
        else r.q[biv_field(t)*32 +: 32] = r.q[biv_field(t)*32 +: 32] + pr;
      end
    end
    r.tp = (ta[2] ^ tb[2]) ? 3'b100 : 3'b000;
    r.tq = 3'b010;
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [2:0] ta, input logic [127:0] a,
                       input logic [2:0] tb, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_tag_a = ta; in_a = a;
    in_tag_b = tb; in_b = b;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(ta, a, tb, b));
    req_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd4(input logic [31:0] seed);
    logic [31:0] s;
    logic [127:0] v;
    s = seed;
    for (int k = 0; k < 4; k++) begin
      s = step(s);
      v[k*32 +: 32] = s;
    end
    return v;
  endfunction

  // monitor: drives out_ready, pops and compares on each transfer
  initial begin
    res_t  e, held;
    string rq;
    bit    was_stalled;
    was_stalled = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (rst_n && was_stalled && out_valid)
        check("R3 held result", {63'b0, out_tag_p, out_tag_q, out_err, out_p, out_q},
              {63'b0, held});
      if (bp_mode) begin
        bp_lfsr = step(bp_lfsr);
        out_ready = bp_lfsr[3];
      end else begin
        out_ready = 1'b1;
      end
      was_stalled = out_valid && !out_ready;
      held = {out_tag_p, out_tag_q, out_err, out_p, out_q};
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected result actual=%h expected=none", out_p);
        end else begin
          e  = exp_q.pop_front();
          rq = req_q.pop_front();
          check(rq, {63'b0, out_tag_p, out_tag_q, out_err, out_p, out_q}, {63'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    res_t m;
    logic [127:0] v1, v2, big;
    logic [2:0] tg [4];
    tg[0] = 3'b001; tg[1] = 3'b101; tg[2] = 3'b001; tg[3] = 3'b101;
    v1 = {32'd4, 32'd3, 32'd2, 32'd1};
    v2 = {32'd8, 32'd7, 32'd6, 32'd5};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid after reset", {255'b0, out_valid}, 256'd0);
    check("R1 in_ready after reset", {255'b0, in_ready}, 256'd1);
    rst_n = 1'b1;

    // R5 hand values of the model: dot 70, e12 = 1*6-2*5
    m = model(3'b001, v1, 3'b001, v2);
    check("R5 scalar sum", {224'b0, m.p}, 256'd70);
    check("R5 e12 field", {224'b0, m.q[31:0]}, {224'b0, -32'sd4});
    // R6 hand value: 5-12+21-32
    m = model(3'b001, v1, 3'b101, v2);
    check("R6 pseudoscalar sum", {224'b0, m.p}, {224'b0, -32'sd18});

    // R2 single transfer, result visible after the accepting edge
    drive("R5 vec x vec", 3'b001, v1, 3'b001, v2);
    idle();
    check("R2 out_valid one edge after accept", {255'b0, out_valid}, 256'd1);

    drive("R6 vec x tri", 3'b001, v1, 3'b101, v2);
    drive("R7 tri x vec", 3'b101, v1, 3'b001, v2);
    drive("R8 tri x tri", 3'b101, v1, 3'b101, v2);
    idle();

    // R4 field placement: single-hot coefficients in each pairing
    for (int i = 0; i < 4; i++) begin
      for (int c = 0; c < 4; c++) begin
        v1 = '0; v2 = '0;
        v1[i*32 +: 32] = 32'd3;
        v2[((i + 1) % 4)*32 +: 32] = 32'd5;
        drive("R4 field placement", tg[c], v1, {tg[c][2] ^ (c > 1), 2'b01}, v2);
      end
    end

    // R10 wraparound on large operands
    big = {4{32'h7FFF_FFFF}};
    drive("R10 wrap vv", 3'b001, big, 3'b001, big);
    drive("R10 wrap vt", 3'b001, big, 3'b101, {4{32'h8000_0001}});

    // R11 unsupported tags
    drive("R11 scalar tag", 3'b000, v1, 3'b001, v2);
    drive("R11 bivector tag", 3'b001, v1, 3'b010, v2);
    drive("R11 pseudoscalar tag", 3'b100, v1, 3'b101, v2);
    drive("R11 tag 111", 3'b111, v1, 3'b011, v2);
    idle();

    // R12 back-to-back burst with the consumer always ready
    repeat (2) @(negedge clk);
    stalls = 0;
    for (int n = 0; n < 24; n++) begin
      lfsr = step(lfsr);
      drive("R12 burst", tg[n % 4], rnd4(lfsr), tg[(n / 4) % 4], rnd4(~lfsr));
    end
    idle();
    check("R12 no stall in burst", 256'(stalls), 256'd0);

    // R3 random back-pressure, R9 tag checked with every result
    bp_mode = 1'b1;
    for (int n = 0; n < 60; n++) begin
      lfsr = step(lfsr);
      drive("R3 back-pressure stream", tg[lfsr[1:0]], rnd4(lfsr), tg[lfsr[3:2]], rnd4(lfsr ^ 32'h5A5A));
      if (lfsr[6]) idle();
    end
    idle();
    bp_mode = 1'b0;

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    check("R2 all results delivered", 256'(exp_q.size()), 256'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule